// File: doc/BRIEF.md
# Parallel-Port Enhanced-Mode Register Bridge

This block sits on the peripheral side of an IEEE 1284 parallel port and lets a host reach a small bank of 16-bit registers through Enhanced Parallel Port (EPP) cycles. After reset it stays passive until the host runs the mode negotiation handshake. The block answers that handshake itself, and from then on it treats address-strobe cycles and data-strobe cycles as register accesses.

An address-strobe cycle with the host writing loads an 8-bit register pointer. Each 16-bit register access then takes two data-strobe cycles: the first carries the low byte and the second the high byte. Every strobe is acknowledged on the busy (wait) line, which rises once the cycle has been taken and falls after the host releases the strobe. On the register side the block issues a one-cycle write strobe with address and word once the high byte has arrived. For reads it issues a one-cycle read request and takes the returned word in that same cycle.

All host pins are brought into the clock domain through a configurable synchronizer before any decision is made. The data bus is split into an input, an output and an output enable.

Top module: `epp_reg_bridge`

## Requirements
- R1: From reset and until negotiation completes, busy is 0 and data_oe is 0, even while a host strobe is held low; the status lines rest at host_perr=0, host_nack=1, host_nfault=1, host_xsel=0.
- R2: With host_nwrite=1, host_nastb=1, host_ndstb=0 and data_in=0x40, the block answers with host_perr=1, host_nack=0, host_nfault=1, host_xsel=1.
- R3: After that answer, host_nwrite going low and then host_nwrite and host_ndstb both high completes negotiation: host_nack=1, host_xsel=1, host_perr=0, host_nfault=1. The block stays in this mode until reset.
- R4: Once negotiated, host_nastb low with host_nwrite=0 loads data_in into the register pointer and raises busy; busy falls after host_nastb returns high.
- R5: Once negotiated, host_ndstb low raises busy, and busy falls after host_ndstb returns high.
- R6: A write is two data cycles with host_nwrite=0. After the second one, wr_stb is high for exactly one cycle with wr_addr equal to the pointer and wr_data equal to {second byte, first byte}. The first byte alone produces no wr_stb.
- R7: Only pointers 0x00 to RW_REGS-1 (default 0x00 to 0x05) are writable; a completed write to any other pointer, including the read-only 0x08 and 0x09, produces no wr_stb.
- R8: A read is two data cycles with host_nwrite=1. The first one raises rd_req for exactly one cycle with rd_addr equal to the pointer and samples rd_data in that cycle. It presents rd_data[7:0] on data_out; the second presents rd_data[15:8] and raises no rd_req.
- R9: data_oe is 1 only while busy is 1 in a host read cycle, and 0 otherwise.
- R10: An address cycle discards a pending low byte, so the next data cycle is again treated as the low byte.
- R11: An address cycle with host_nwrite=1 drives the current pointer on data_out and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_nwrite | input | 1 | Cycle direction from host: 0 = host writes, 1 = host reads |
| host_nastb | input | 1 | Address strobe, active low |
| host_ndstb | input | 1 | Data strobe, active low |
| data_in | input | 8 | Host data bus as seen by the block |
| data_out | output | 8 | Byte driven to the host in read cycles |
| data_oe | output | 1 | Output enable for data_out |
| busy | output | 1 | Strobe acknowledge / wait line |
| host_perr | output | 1 | Paper-error status line used in negotiation |
| host_nack | output | 1 | Acknowledge status line, active low |
| host_nfault | output | 1 | Fault status line, active low |
| host_xsel | output | 1 | Select status line |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register address for a write |
| wr_data | output | 16 | Register word for a write |
| rd_req | output | 1 | One-cycle register read request |
| rd_addr | output | 8 | Register address for a read |
| rd_data | input | 16 | Register word returned in the rd_req cycle |

## Verification
The assertions rely on the host following the interlocked handshake: it keeps data_in and host_nwrite stable for the whole of a strobe's low phase, never asserts both strobes at once, and does not lower a new strobe before busy has fallen. They also rely on the register side presenting rd_data in the same cycle as rd_req. The bench plays a host that changes pins only on the falling clock edge and always waits for busy to rise before it releases a strobe and for busy to fall before the next one. Its register responder is a pure function of rd_addr.

// File: rtl/epp_bridge_pkg.sv
package epp_bridge_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam logic [BYTE_W-1:0] NEG_REQUEST_CODE = 8'h40;

    typedef struct packed {
        logic              nwrite;
        logic              nastb;
        logic              ndstb;
        logic [BYTE_W-1:0] data;
    } host_pins_t;

    localparam host_pins_t HOST_IDLE = '{nwrite: 1'b1, nastb: 1'b1, ndstb: 1'b1, data: '0};

    typedef struct packed {
        logic perr;
        logic nack;
        logic nfault;
        logic xsel;
    } link_status_t;

    typedef enum logic [1:0] {
        NEG_WAIT,
        NEG_ANSWER,
        NEG_CLOSE,
        NEG_EPP
    } neg_state_t;

    typedef enum logic [1:0] {
        CYC_IDLE,
        CYC_ADDR,
        CYC_FETCH,
        CYC_DATA
    } cyc_state_t;

    function automatic link_status_t status_for(neg_state_t s);
        link_status_t r;
        unique case (s)
            NEG_ANSWER, NEG_CLOSE: r = '{perr: 1'b1, nack: 1'b0, nfault: 1'b1, xsel: 1'b1};
            NEG_EPP:               r = '{perr: 1'b0, nack: 1'b1, nfault: 1'b1, xsel: 1'b1};
            default:               r = '{perr: 1'b0, nack: 1'b1, nfault: 1'b1, xsel: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/epp_pin_sync.sv
module epp_pin_sync
    import epp_bridge_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  host_pins_t raw,
    output host_pins_t synced
);
    host_pins_t chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[i] <= HOST_IDLE;
                end else if (i == 0) begin
                    chain[i] <= raw;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i - 1];
                end
            end
        end
    endgenerate

    assign synced = chain[STAGES-1];

endmodule

// File: rtl/epp_negotiator.sv
module epp_negotiator
    import epp_bridge_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  host_pins_t   pins,
    output link_status_t status,
    output logic         epp_on
);
    neg_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= NEG_WAIT;
        end else begin
            unique case (state)
                NEG_WAIT:
                    if (pins.nwrite && pins.nastb && !pins.ndstb && pins.data == NEG_REQUEST_CODE)
                        state <= NEG_ANSWER;
                NEG_ANSWER:
                    if (!pins.nwrite) state <= NEG_CLOSE;
                NEG_CLOSE:
                    if (pins.nwrite && pins.ndstb) state <= NEG_EPP;
                default:
                    state <= NEG_EPP;
            endcase
        end
    end

    assign status = status_for(state);
    assign epp_on = (state == NEG_EPP);

    // R3: once negotiated, the mode holds until reset
    assert_epp_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        epp_on |=> epp_on);

    // R2: the negotiation answer always shows perr and select together with nack low
    assert_answer_lines_R2: assert property (@(posedge clk) disable iff (rst)
        !status.nack |-> (status.perr && status.xsel && status.nfault));

endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
    import epp_bridge_pkg::*;
#(
    parameter int RW_REGS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  host_pins_t        pins,
    input  logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              data_oe,
    output logic [BYTE_W-1:0] data_out,
    output logic [BYTE_W-1:0] reg_addr,
    output logic              wr_stb,
    output logic [WORD_W-1:0] wr_data,
    output logic              rd_req
);
    localparam logic [BYTE_W-1:0] RW_LIMIT = BYTE_W'(RW_REGS);

    cyc_state_t        state;
    logic              high_phase;
    logic [BYTE_W-1:0] low_byte;
    logic [BYTE_W-1:0] high_hold;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state      <= CYC_IDLE;
            busy       <= 1'b0;
            data_oe    <= 1'b0;
            data_out   <= '0;
            reg_addr   <= '0;
            high_phase <= 1'b0;
            low_byte   <= '0;
            high_hold  <= '0;
            wr_stb     <= 1'b0;
            wr_data    <= '0;
            rd_req     <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            rd_req <= 1'b0;
            unique case (state)
                CYC_IDLE: begin
                    if (!pins.nastb) begin
                        busy       <= 1'b1;
                        high_phase <= 1'b0;
                        if (!pins.nwrite) begin
                            reg_addr <= pins.data;
                        end else begin
                            data_out <= reg_addr;
                            data_oe  <= 1'b1;
                        end
                        state <= CYC_ADDR;
                    end else if (!pins.ndstb) begin
                        if (!pins.nwrite) begin
                            busy <= 1'b1;
                            if (!high_phase) begin
                                low_byte   <= pins.data;
                                high_phase <= 1'b1;
                            end else begin
                                high_phase <= 1'b0;
                                wr_data    <= {pins.data, low_byte};
                                wr_stb     <= (reg_addr < RW_LIMIT);
                            end
                            state <= CYC_DATA;
                        end else if (!high_phase) begin
                            rd_req <= 1'b1;
                            state  <= CYC_FETCH;
                        end else begin
                            busy       <= 1'b1;
                            data_oe    <= 1'b1;
                            data_out   <= high_hold;
                            high_phase <= 1'b0;
                            state      <= CYC_DATA;
                        end
                    end
                end
                CYC_FETCH: begin
                    high_hold  <= rd_data[WORD_W-1:BYTE_W];
                    data_out   <= rd_data[BYTE_W-1:0];
                    data_oe    <= 1'b1;
                    busy       <= 1'b1;
                    high_phase <= 1'b1;
                    state      <= CYC_DATA;
                end
                CYC_ADDR: begin
                    if (pins.nastb) begin
                        busy    <= 1'b0;
                        data_oe <= 1'b0;
                        state   <= CYC_IDLE;
                    end
                end
                default: begin
                    if (pins.ndstb) begin
                        busy    <= 1'b0;
                        data_oe <= 1'b0;
                        state   <= CYC_IDLE;
                    end
                end
            endcase
        end
    end

    // R9: the bus is only driven while a cycle is being acknowledged
    assert_oe_within_busy_R9: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> busy);

    // R7: no write strobe ever reaches a pointer outside the writable range
    assert_no_ro_write_R7: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (reg_addr < RW_LIMIT));

    // R6: the write strobe lasts one cycle
    assert_wr_single_R6: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R8: a read request is followed by the low byte being driven under busy
    assert_fetch_drives_R8: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> (busy && data_oe && !rd_req));

    // R1: nothing is acknowledged before negotiation completes
    assert_quiet_before_epp_R1: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!busy && !data_oe));

endmodule

// File: rtl/epp_reg_bridge.sv
module epp_reg_bridge
    import epp_bridge_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RW_REGS     = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_nwrite,
    input  logic        host_nastb,
    input  logic        host_ndstb,
    input  logic [7:0]  data_in,
    output logic [7:0]  data_out,
    output logic        data_oe,
    output logic        busy,
    output logic        host_perr,
    output logic        host_nack,
    output logic        host_nfault,
    output logic        host_xsel,
    output logic        wr_stb,
    output logic [7:0]  wr_addr,
    output logic [15:0] wr_data,
    output logic        rd_req,
    output logic [7:0]  rd_addr,
    input  logic [15:0] rd_data
);
    host_pins_t   raw_pins;
    host_pins_t   sync_pins;
    link_status_t status;
    logic         epp_on;
    logic [7:0]   reg_addr;

    assign raw_pins = '{nwrite: host_nwrite, nastb: host_nastb, ndstb: host_ndstb, data: data_in};

    epp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw_pins),
        .synced (sync_pins)
    );

    epp_negotiator u_neg (
        .clk    (clk),
        .rst    (rst),
        .pins   (sync_pins),
        .status (status),
        .epp_on (epp_on)
    );

    epp_cycle_engine #(.RW_REGS(RW_REGS)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .enable   (epp_on),
        .pins     (sync_pins),
        .rd_data  (rd_data),
        .busy     (busy),
        .data_oe  (data_oe),
        .data_out (data_out),
        .reg_addr (reg_addr),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .rd_req   (rd_req)
    );

    assign host_perr   = status.perr;
    assign host_nack   = status.nack;
    assign host_nfault = status.nfault;
    assign host_xsel   = status.xsel;
    assign wr_addr     = reg_addr;
    assign rd_addr     = reg_addr;

endmodule

// File: tb/sim_epp_reg_bridge.sv
module sim_epp_reg_bridge;
    localparam time CLK_PERIOD = 10ns;
    localparam int  RW_REGS    = 6;
    localparam int  WAIT_LIMIT = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_nwrite = 1'b1;
    logic        host_nastb  = 1'b1;
    logic        host_ndstb  = 1'b1;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe, busy, host_perr, host_nack, host_nfault, host_xsel;
    logic        wr_stb, rd_req;
    logic [7:0]  wr_addr, rd_addr;
    logic [15:0] wr_data, rd_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int wr_count = 0;
    int rd_count = 0;
    logic [7:0]  last_wr_addr = '0;
    logic [15:0] last_wr_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] resp(input logic [7:0] a);
        return {a ^ 8'h5A, a + 8'h31};
    endfunction

    function automatic logic [15:0] wval(input int a);
        return 16'((a * 16'h1111) ^ 16'hA5C3);
    endfunction

    assign rd_data = resp(rd_addr);

    epp_reg_bridge #(.SYNC_STAGES(2), .RW_REGS(RW_REGS)) u0 (
        .clk(clk), .rst(rst), .host_nwrite(host_nwrite), .host_nastb(host_nastb),
        .host_ndstb(host_ndstb), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .busy(busy), .host_perr(host_perr), .host_nack(host_nack), .host_nfault(host_nfault),
        .host_xsel(host_xsel), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (wr_stb) begin
            wr_count     <= wr_count + 1;
            last_wr_addr <= wr_addr;
            last_wr_data <= wr_data;
        end
        if (rd_req) rd_count <= rd_count + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_busy(input logic level, input string req);
        int n = 0;
        while (busy !== level && n < WAIT_LIMIT) begin
            @(negedge clk);
            n++;
        end
        check(busy === level, req, {31'd0, busy}, {31'd0, level});
    endtask

    // R4: address write cycle
    task automatic addr_write(input logic [7:0] a);
        @(negedge clk);
        host_nwrite = 1'b0; data_in = a; host_nastb = 1'b0;
        wait_busy(1'b1, "R4 busy rise");
        host_nastb = 1'b1;
        wait_busy(1'b0, "R4 busy fall");
        host_nwrite = 1'b1;
    endtask

    // R11: address read cycle
    task automatic addr_read(output logic [7:0] a);
        @(negedge clk);
        host_nwrite = 1'b1; host_nastb = 1'b0;
        wait_busy(1'b1, "R11 busy rise");
        a = data_out;
        check(data_oe === 1'b1, "R11 oe", {31'd0, data_oe}, 32'd1);
        host_nastb = 1'b1;
        wait_busy(1'b0, "R11 busy fall");
    endtask

    // R5: data write cycle
    task automatic byte_write(input logic [7:0] b);
        @(negedge clk);
        host_nwrite = 1'b0; data_in = b; host_ndstb = 1'b0;
        wait_busy(1'b1, "R5 busy rise");
        check(data_oe === 1'b0, "R9 oe in write", {31'd0, data_oe}, 32'd0);
        host_ndstb = 1'b1;
        wait_busy(1'b0, "R5 busy fall");
        host_nwrite = 1'b1;
    endtask

    task automatic byte_read(output logic [7:0] b);
        @(negedge clk);
        host_nwrite = 1'b1; host_ndstb = 1'b0;
        wait_busy(1'b1, "R5 busy rise read");
        b = data_out;
        check(data_oe === 1'b1, "R9 oe in read", {31'd0, data_oe}, 32'd1);
        host_ndstb = 1'b1;
        wait_busy(1'b0, "R5 busy fall read");
        check(data_oe === 1'b0, "R9 oe released", {31'd0, data_oe}, 32'd0);
    endtask

    initial begin : watchdog
        wait (cycles > 100000);
        check(1'b0, "watchdog", cycles, 100000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] lo, hi, ra;
        int w0, r0;
        idle(4);
        rst = 1'b0;
        idle(2);

        // R1: rest state
        check(busy === 1'b0 && data_oe === 1'b0, "R1 reset busy/oe", {30'd0, busy, data_oe}, 0);
        check({host_perr, host_nack, host_nfault, host_xsel} === 4'b0110, "R1 reset status",
              {28'd0, host_perr, host_nack, host_nfault, host_xsel}, 32'h6);
        host_nwrite = 1'b0; host_nastb = 1'b0;
        idle(10);
        check(busy === 1'b0, "R1 strobe before negotiation", {31'd0, busy}, 0);
        host_nastb = 1'b1; host_nwrite = 1'b1;
        idle(4);

        // R2: negotiation request
        data_in = 8'h40; host_ndstb = 1'b0;
        idle(6);
        check({host_perr, host_nack, host_nfault, host_xsel} === 4'b1011, "R2 answer",
              {28'd0, host_perr, host_nack, host_nfault, host_xsel}, 32'hB);
        check(busy === 1'b0, "R1 no busy during negotiation", {31'd0, busy}, 0);

        // R3: close negotiation
        host_nwrite = 1'b0;
        idle(6);
        host_nwrite = 1'b1; host_ndstb = 1'b1;
        idle(6);
        check({host_perr, host_nack, host_nfault, host_xsel} === 4'b0111, "R3 done lines",
              {28'd0, host_perr, host_nack, host_nfault, host_xsel}, 32'h7);

        // R6 / R7: sweep every pointer 0..15
        for (int a = 0; a < 16; a++) begin
            addr_write(8'(a));
            w0 = wr_count;
            byte_write(wval(a)[7:0]);
            idle(2);
            check(wr_count == w0, "R6 no strobe after low byte", wr_count, w0);
            byte_write(wval(a)[15:8]);
            idle(2);
            if (a < RW_REGS) begin
                check(wr_count == w0 + 1, "R6 one strobe", wr_count, w0 + 1);
                check(last_wr_addr == 8'(a), "R6 addr", last_wr_addr, a);
                check(last_wr_data == wval(a), "R6 data", last_wr_data, wval(a));
            end else begin
                check(wr_count == w0, "R7 read-only ignored", wr_count, w0);
            end
        end

        // R8: read sweep
        for (int a = 0; a < 16; a++) begin
            addr_write(8'(a) ^ 8'hC0);
            r0 = rd_count;
            byte_read(lo);
            byte_read(hi);
            idle(2);
            check({hi, lo} == resp(8'(a) ^ 8'hC0), "R8 word", {hi, lo}, resp(8'(a) ^ 8'hC0));
            check(rd_count == r0 + 1, "R8 single request", rd_count, r0 + 1);
        end

        // R10: address cycle resets byte phase
        addr_write(8'h02);
        byte_write(8'hEE);
        addr_write(8'h03);
        w0 = wr_count;
        byte_write(8'h34);
        byte_write(8'h12);
        idle(2);
        check(wr_count == w0 + 1, "R10 strobe count", wr_count, w0 + 1);
        check(last_wr_data == 16'h1234 && last_wr_addr == 8'h03, "R10 phase reset",
              {last_wr_addr, last_wr_data}, {8'h03, 16'h1234});

        // R11: address read returns pointer and keeps it
        addr_write(8'h04);
        addr_read(ra);
        check(ra == 8'h04, "R11 pointer readback", ra, 8'h04);
        byte_write(8'h78);
        byte_write(8'h56);
        idle(2);
        check(last_wr_addr == 8'h04 && last_wr_data == 16'h5678, "R11 pointer kept",
              {last_wr_addr, last_wr_data}, {8'h04, 16'h5678});

        // R3: mode held after traffic
        check(host_nack === 1'b1 && host_xsel === 1'b1, "R3 mode held",
              {30'd0, host_nack, host_xsel}, 32'h3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule